// File: doc/BRIEF.md
# Length-Prefixed Transmit Packet Buffer

This block holds one outgoing frame between a host register port and a transmit MAC. The host fills a small byte-addressed store. The byte at the lowest host address is a length field. The address, frame-control and payload bytes follow it at rising addresses. The length field counts only those trailing bytes and not itself.

When the host pulses the start input, the block reads the length field and checks it against a fixed window. If the length is in range, the block sends the length byte and then exactly that many stored bytes to the MAC over a byte-wide valid/ready stream. It flags the final byte and then reports completion. If the length is out of range, the transmit is abandoned: the block reports an error and sends no byte. While a frame is being sent, the store is locked against host writes and further start pulses have no effect.

Top module: `txpkt_buf`

## Requirements
- R1: After reset, tx_busy, tx_done, tx_err and m_valid are 0, and every stored byte reads back as 0.
- R2: Host addresses 0x001 to 0x03E (62 bytes) form the store. A write with host_we=1 updates the byte at host_addr, and host_rdata returns that byte combinationally in the same cycle as host_addr. Address 0x001 holds the length field, and address 0x001+k holds frame byte k.
- R3: A write to any address outside 0x001..0x03E changes no stored byte, and a read from such an address returns 0.
- R4: A start pulse while idle with a length field from 5 to 61 sends length+1 bytes in this order: the length byte, then the bytes at 0x002 up to 0x001+length, one byte per accepted handshake (m_valid and m_ready both 1).
- R5: m_last is 1 on the final byte of a frame and 0 on every earlier byte.
- R6: While m_valid is 1 and m_ready is 0, m_data and m_last hold their values into the next cycle and m_valid stays 1.
- R7: A start pulse while idle with a length field of 0 to 4 or 62 to 255 sets tx_err to 1 for exactly one cycle, starting the cycle after the pulse. No byte is sent and tx_busy stays 0.
- R8: tx_done is 1 for exactly one cycle, the cycle after the last byte is accepted. In that same cycle tx_busy and m_valid are 0.
- R9: tx_busy is 1 from the cycle after a valid start until the last byte is accepted. A start pulse while tx_busy is 1 is ignored and does not restart or lengthen the frame.
- R10: Host writes made while tx_busy is 1 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 10 | Host byte address |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| tx_start | input | 1 | Transmit request pulse |
| tx_busy | output | 1 | Frame being streamed |
| tx_done | output | 1 | One-cycle completion pulse |
| tx_err | output | 1 | One-cycle bad-length pulse |
| m_valid | output | 1 | Stream byte valid |
| m_data | output | 8 | Stream byte |
| m_last | output | 1 | Final byte of frame |
| m_ready | input | 1 | MAC accepts byte |

## Verification
The assertions check these rules on every cycle:
- a stalled byte stays stable;
- tx_done follows the flagged final handshake and lasts one cycle;
- an error pulse never coincides with stream output;
- a start pulse during streaming does not disturb the stream position;
- no store write lands while the block is busy;
- the first byte of every frame lies inside the length window.

Only the bench's scenarios can show the rest:
- the exact byte sequence and byte count for a given stored length;
- address decoding at both edges of the window;
- the lengths on each side of the accepted range;
- that a write attempted mid-frame is really lost once the frame ends.

// File: rtl/txpkt_pkg.sv
`timescale 1ns/1ps
package txpkt_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/txpkt_mem.sv
`timescale 1ns/1ps
module txpkt_mem #(
    parameter int DEPTH = 62,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [7:0]       rd_a_data,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [7:0]       rd_b_data,
    output logic [7:0]       head_data
);

    logic [7:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [7:0] cell_d;
        logic [7:0] cell_q;

        always_comb begin
            cell_d = cell_q;
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                cell_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else begin
                cell_q <= cell_d;
            end
        end

        assign cells[g] = cell_q;
    end

    assign rd_a_data = (int'(rd_a_idx) < DEPTH) ? cells[rd_a_idx] : '0;
    assign rd_b_data = (int'(rd_b_idx) < DEPTH) ? cells[rd_b_idx] : '0;
    assign head_data = cells[0];

    AST_NO_WRITE_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> !wr_en); // R10

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < DEPTH)); // R3

endmodule

// File: rtl/txpkt_host.sv
`timescale 1ns/1ps
module txpkt_host #(
    parameter int ADDR_W = 10,
    parameter int BASE   = 1,
    parameter int DEPTH  = 62,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic [7:0]        host_wdata,
    input  logic              busy,
    input  logic [7:0]        cell_rdata,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [7:0]        mem_wdata,
    output logic [7:0]        host_rdata
);

    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE + DEPTH - 1);

    logic in_range;

    always_comb begin
        in_range   = (host_addr >= LO_ADDR) && (host_addr <= HI_ADDR);
        mem_idx    = IDX_W'(host_addr - LO_ADDR);
        mem_we     = host_we && in_range && !busy;
        mem_wdata  = host_wdata;
        host_rdata = in_range ? cell_rdata : '0;
    end

endmodule

// File: rtl/txpkt_stream.sv
`timescale 1ns/1ps
module txpkt_stream
    import txpkt_pkg::*;
#(
    parameter int DEPTH   = 62,
    parameter int IDX_W   = $clog2(DEPTH),
    parameter int MIN_LEN = 5,
    parameter int MAX_LEN = 61
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       len_byte,
    input  logic [7:0]       cur_byte,
    input  logic             m_ready,
    output logic [IDX_W-1:0] rd_idx,
    output logic             m_valid,
    output logic [7:0]       m_data,
    output logic             m_last,
    output logic             busy,
    output logic             done,
    output logic             err
);

    localparam int LEN_W = BYTE_W;

    typedef struct packed {
        tx_state_e        state;
        logic [IDX_W-1:0] idx;
        logic [LEN_W-1:0] len;
        logic             done;
        logic             err;
    } strm_t;

    strm_t st_d, st_q;
    logic  len_ok;
    logic  at_end;

    always_comb begin
        len_ok = (len_byte >= LEN_W'(MIN_LEN)) && (len_byte <= LEN_W'(MAX_LEN));
        at_end = (LEN_W'(st_q.idx) == st_q.len);

        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;

        unique case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (len_ok) begin
                        st_d.state = ST_SEND;
                        st_d.idx   = '0;
                        st_d.len   = len_byte;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
            end
            ST_SEND: begin
                if (m_ready) begin
                    if (at_end) begin
                        st_d.state = ST_IDLE;
                        st_d.idx   = '0;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_idx  = st_q.idx;
    assign m_valid = (st_q.state == ST_SEND);
    assign m_data  = cur_byte;
    assign m_last  = m_valid && at_end;
    assign busy    = m_valid;
    assign done    = st_q.done;
    assign err     = st_q.err;

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last))); // R6

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_last) |=> (done && !m_valid)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!m_valid && !busy)); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !m_ready) |=> (m_valid && $stable(rd_idx))); // R9

    AST_FIRST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_valid) |-> ((m_data >= 8'(MIN_LEN)) && (m_data <= 8'(MAX_LEN)))); // R4

endmodule

// File: rtl/txpkt_buf.sv
`timescale 1ns/1ps
module txpkt_buf #(
    parameter int ADDR_W  = 10,
    parameter int BASE    = 1,
    parameter int DEPTH   = 62,
    parameter int MIN_LEN = 5,
    parameter int MAX_LEN = 61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              tx_start,
    output logic              tx_busy,
    output logic              tx_done,
    output logic              tx_err,
    output logic              m_valid,
    output logic [7:0]        m_data,
    output logic              m_last,
    input  logic              m_ready
);

    localparam int IDX_W = $clog2(DEPTH);

    logic             mem_we;
    logic [IDX_W-1:0] host_idx;
    logic [7:0]       mem_wdata;
    logic [7:0]       host_cell;
    logic [IDX_W-1:0] strm_idx;
    logic [7:0]       strm_cell;
    logic [7:0]       head_cell;
    logic             busy;

    txpkt_host #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE),
        .DEPTH  (DEPTH),
        .IDX_W  (IDX_W)
    ) u_host (
        .host_addr  (host_addr),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .busy       (busy),
        .cell_rdata (host_cell),
        .mem_we     (mem_we),
        .mem_idx    (host_idx),
        .mem_wdata  (mem_wdata),
        .host_rdata (host_rdata)
    );

    txpkt_mem #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock      (busy),
        .wr_en     (mem_we),
        .wr_idx    (host_idx),
        .wr_data   (mem_wdata),
        .rd_a_idx  (host_idx),
        .rd_a_data (host_cell),
        .rd_b_idx  (strm_idx),
        .rd_b_data (strm_cell),
        .head_data (head_cell)
    );

    txpkt_stream #(
        .DEPTH   (DEPTH),
        .IDX_W   (IDX_W),
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN)
    ) u_stream (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tx_start),
        .len_byte (head_cell),
        .cur_byte (strm_cell),
        .m_ready  (m_ready),
        .rd_idx   (strm_idx),
        .m_valid  (m_valid),
        .m_data   (m_data),
        .m_last   (m_last),
        .busy     (busy),
        .done     (tx_done),
        .err      (tx_err)
    );

    assign tx_busy = busy;

endmodule

// File: tb/txpkt_buf_tb.sv
`timescale 1ns/1ps
module txpkt_buf_tb;

    typedef struct packed {
        logic [7:0] len;
        logic [7:0] stall;
        logic [7:0] seed;
    } fvec_t;

    localparam int NVEC = 9;
    localparam fvec_t VECS [NVEC] = '{
        '{len: 8'd5,   stall: 8'h00, seed: 8'h11},
        '{len: 8'd61,  stall: 8'hB2, seed: 8'h3C},
        '{len: 8'd33,  stall: 8'h49, seed: 8'h07},
        '{len: 8'd6,   stall: 8'hFE, seed: 8'hA5},
        '{len: 8'd4,   stall: 8'h00, seed: 8'h22},
        '{len: 8'd62,  stall: 8'h00, seed: 8'h23},
        '{len: 8'd0,   stall: 8'h00, seed: 8'h24},
        '{len: 8'd255, stall: 8'h00, seed: 8'h25},
        '{len: 8'd60,  stall: 8'h0F, seed: 8'h5A}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] host_addr = '0;
    logic       host_we = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       tx_start = 1'b0;
    logic       tx_busy, tx_done, tx_err;
    logic       m_valid, m_last;
    logic [7:0] m_data;
    logic       m_ready = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    txpkt_buf u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .tx_start   (tx_start),
        .tx_busy    (tx_busy),
        .tx_done    (tx_done),
        .tx_err     (tx_err),
        .m_valid    (m_valid),
        .m_data     (m_data),
        .m_last     (m_last),
        .m_ready    (m_ready)
    );

    function automatic logic [7:0] pat(input int a, input logic [7:0] seed);
        return 8'((a * 29 + int'(seed)) ^ (a >> 1));
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic host_write(input int addr, input logic [7:0] data);
        @(negedge clk);
        host_addr  = 10'(addr);
        host_wdata = data;
        host_we    = 1'b1;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic host_read(input int addr, output logic [7:0] data);
        @(negedge clk);
        host_addr = 10'(addr);
        #1;
        data = host_rdata;
    endtask

    task automatic load_frame(input logic [7:0] len, input logic [7:0] seed);
        host_write(1, len);
        if (len >= 8'd5 && len <= 8'd61) begin
            for (int a = 2; a <= int'(len) + 1; a++) begin
                host_write(a, pat(a, seed));
            end
        end
    endtask

    // Pulses start and collects the frame; poke=1 also tries a restart and a
    // host write on the first streaming cycle with the MAC stalled.
    task automatic send_frame(input logic [7:0] len, input logic [7:0] stall,
                              input logic [7:0] seed, input logic poke);
        int got;
        int cyc;
        logic expect_ok;
        logic prev_stall;
        logic [7:0] prev_data;
        logic [7:0] expb;
        expect_ok = (len >= 8'd5) && (len <= 8'd61);
        @(negedge clk);
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        if (!expect_ok) begin
            check(tx_err == 1'b1, "R7 err pulse", int'(tx_err), 1);
            check(m_valid == 1'b0 && tx_busy == 1'b0, "R7 nothing sent", int'(m_valid), 0);
            @(negedge clk);
            check(tx_err == 1'b0, "R7 err one cycle", int'(tx_err), 0);
            check(m_valid == 1'b0, "R7 still silent", int'(m_valid), 0);
            return;
        end
        check(tx_busy == 1'b1, "R9 busy after start", int'(tx_busy), 1);
        got = 0;
        cyc = 0;
        prev_stall = 1'b0;
        prev_data  = '0;
        while (got <= int'(len) && cyc < 600) begin
            if (poke && cyc == 0) begin
                m_ready    = 1'b0;
                tx_start   = 1'b1;
                host_we    = 1'b1;
                host_addr  = 10'd1;
                host_wdata = 8'd3;
            end else begin
                m_ready = !stall[cyc % 8];
            end
            #1;
            if (prev_stall) begin
                check(m_valid == 1'b1 && m_data == prev_data, "R6 stall hold",
                      int'(m_data), int'(prev_data));
            end
            if (m_valid && m_ready) begin
                expb = (got == 0) ? len : pat(got + 1, seed);
                check(m_data == expb, "R4 byte value", int'(m_data), int'(expb));
                check(m_last == (got == int'(len)), "R5 last flag", int'(m_last),
                      int'(got == int'(len)));
                got++;
            end
            prev_stall = m_valid && !m_ready;
            prev_data  = m_data;
            @(negedge clk);
            tx_start = 1'b0;
            host_we  = 1'b0;
            cyc++;
        end
        m_ready = 1'b0;
        check(got == int'(len) + 1, "R4 byte count", got, int'(len) + 1);
        check(tx_done == 1'b1, "R8 done after last", int'(tx_done), 1);
        check(tx_busy == 1'b0 && m_valid == 1'b0, "R8 idle with done", int'(tx_busy), 0);
        @(negedge clk);
        check(tx_done == 1'b0, "R8 done one cycle", int'(tx_done), 0);
        check(m_valid == 1'b0, "R9 no restart", int'(m_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(!tx_busy && !tx_done && !tx_err && !m_valid, "R1 idle outputs",
              int'({tx_busy, tx_done, tx_err, m_valid}), 0);
        host_read(1, rd);
        check(rd == 8'd0, "R1 cell 0x001", int'(rd), 0);
        host_read(62, rd);
        check(rd == 8'd0, "R1 cell 0x03E", int'(rd), 0);
        // R7: length 0 after reset is rejected
        send_frame(8'd0, 8'h00, 8'h00, 1'b0);

        // R2 edges of window
        host_write(62, 8'hC3);
        host_read(62, rd);
        check(rd == 8'hC3, "R2 write/read 0x03E", int'(rd), 'hC3);
        host_write(1, 8'h5D);
        host_read(1, rd);
        check(rd == 8'h5D, "R2 write/read 0x001", int'(rd), 'h5D);

        // R3 outside window
        host_write(0, 8'hAA);
        host_write(63, 8'hBB);
        host_write(64, 8'hCC);
        host_write(1023, 8'hDD);
        host_read(0, rd);
        check(rd == 8'd0, "R3 read 0x000", int'(rd), 0);
        host_read(63, rd);
        check(rd == 8'd0, "R3 read 0x03F", int'(rd), 0);
        host_read(62, rd);
        check(rd == 8'hC3, "R3 no alias 0x03E", int'(rd), 'hC3);
        host_read(1, rd);
        check(rd == 8'h5D, "R3 no alias 0x001", int'(rd), 'h5D);
        host_read(2, rd);
        check(rd == 8'd0, "R3 no alias 0x002", int'(rd), 0);

        // vector walk: R4 R5 R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            load_frame(VECS[v].len, VECS[v].seed);
            send_frame(VECS[v].len, VECS[v].stall, VECS[v].seed, 1'b0);
        end

        // R9 and R10: restart and write attempted mid-frame
        load_frame(8'd10, 8'h77);
        send_frame(8'd10, 8'h00, 8'h77, 1'b1);
        host_read(1, rd);
        check(rd == 8'd10, "R10 write while busy dropped", int'(rd), 10);

        // re-send same frame, unchanged: R4 with stored data intact
        send_frame(8'd10, 8'h55, 8'h77, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule